// File: doc/BRIEF.md
# Display Data Channel I2C Master

This block is an I2C master for the display data channel of a video transmitter. A host controls it through a small register file with byte-wide registers. The host writes a 7-bit target address, a sub-register address and, for a write, one data byte. It then writes an operation code. Each accepted operation runs one complete single-byte transaction on the open-drain SCL and SDA lines and then reports exactly one outcome.

A write runs START, address+W, sub-address, data byte, STOP. A read runs START, address+W, sub-address, repeated START, address+R, one data byte that the master does not acknowledge, STOP. The received byte is then held in a data-in register.

The outcome is latched in a two-bit status register, cleared by writing ones: bit 1 (0x02) means the transaction completed, bit 0 (0x01) means it failed. A failure is a NACK or lost arbitration. A mute register with the same layout keeps the interrupt line from showing a latched bit. A report-select register chooses which event sources set status at all. A soft-reset write abandons a transaction and frees the bus. The host steps through sub-addresses itself, one command at a time.

Register map (4-bit offset): 0 target address (bits 6:0), 1 sub-address, 2 data out, 3 data in (read only), 4 operation (reads 0), 5 status, 6 mute, 7 divider, 8 soft reset (reads 0x01), 9 report select. Other offsets read 0.

Top module: `ddc_i2c_master`

## Requirements
- R1: After reset the status is 0x00, mute is 0x03, divider is 0x0B, report select is 0x07, the target address is 0, irq is low and both bus lines are released.
- R2: Writing 0x10 to offset 4 while idle runs START, address+W, sub-address, the data-out byte and STOP. Without a NACK, status bit 1 (0x02) is set, and it is the only event raised for that operation.
- R3: Writing 0x01 to offset 4 while idle runs START, address+W, sub-address, repeated START, address+R, one byte with master NACK, and STOP. Then status bit 1 is set and offset 3 holds the byte the target returned.
- R4: A NACK from the target in any acknowledge slot makes the master issue STOP and set status bit 0 (0x01) but not bit 1.
- R5: If SDA reads low while the master releases it to send a 1 during a transmitted bit, the master releases both lines at once, sends no further clocks and sets status bit 0.
- R6: Writing a 1 to a status bit clears that bit and leaves the other one untouched. An event in the same cycle wins over the clear.
- R7: irq is high exactly when a status bit is set whose bit in mute (offset 6) is clear. A muted bit still latches and shows up once it is unmuted.
- R8: A write to offset 4 while a transaction is in progress is ignored. So is any value other than 0x01 or 0x10, including the reserved 0x02. An ignored write starts no transaction and raises no status.
- R9: Writing 0x00 to offset 8 returns the engine to idle within one cycle, releases both lines and raises no status.
- R10: Each SCL phase lasts divider+1 clock cycles. SCL has a period of 4*(divider+1) cycles, high for 2*(divider+1) of them, and the master changes SDA while SCL is high only to form START and STOP.
- R11: Offset 9 bit 0 enables done reporting, bit 1 NACK reporting and bit 2 arbitration reporting. With a bit cleared, that event runs its normal bus sequence but sets no status.
- R12: The target address in offset 0 applies to every later operation until it is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data, combinational from host_addr |
| irq | output | 1 | Interrupt, high while any unmuted status bit is set |
| scl_i | input | 1 | SCL level on the bus |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_i | input | 1 | SDA level on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest state to reach from the ports is lost arbitration. It needs a second driver that pulls SDA low in the exact window where the master has released SDA to send a 1 and SCL is high. A correct target never does this. The bench therefore has a rogue driver that it arms at the first SCL fall after START. The address byte starts with a 1, so the master's first sample catches the conflict. The tests for ignored operations and for soft reset also depend on timing: they issue their writes part-way through a running transaction and then count START conditions on the bus to show that no second transaction began.

// File: rtl/ddc_i2c_master.sv
module ddc_i2c_master #(
  parameter logic [7:0] DIV_RESET = 8'h0B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq,
  input  logic       scl_i,
  output logic       scl_oe,
  input  logic       sda_i,
  output logic       sda_oe
);
  localparam logic [3:0] A_DEV = 4'd0, A_SUB = 4'd1, A_DOUT = 4'd2, A_DIN = 4'd3,
                         A_OP = 4'd4, A_STAT = 4'd5, A_MUTE = 4'd6, A_DIV = 4'd7,
                         A_SRST = 4'd8, A_POL = 4'd9;

  typedef enum logic [2:0] {S_IDLE, S_START, S_TX, S_RX, S_STOP} st_t;

  st_t        st;
  logic [6:0] dev;
  logic [7:0] sub, dout, din, div, cnt, shift;
  logic [1:0] stat, mute, ph, step;
  logic [2:0] pol;
  logic [3:0] bitn;
  logic       rd_op, rep, fail, nack_s;
  logic       ev_done, ev_nack, ev_arb;

  wire op_go = host_we && host_addr == A_OP && st == S_IDLE &&
               (host_wdata == 8'h01 || host_wdata == 8'h10);
  wire srst  = host_we && host_addr == A_SRST && host_wdata == 8'h00;
  wire tick  = st != S_IDLE && cnt == div;
  wire [1:0] clr = (host_we && host_addr == A_STAT) ? host_wdata[1:0] : 2'b00;

  assign irq = |(stat & ~mute);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev <= '0; sub <= '0; dout <= '0; mute <= 2'b11;
      div <= DIV_RESET; pol <= 3'b111; stat <= '0;
    end else begin
      if (host_we) begin
        case (host_addr)
          A_DEV:  dev  <= host_wdata[6:0];
          A_SUB:  sub  <= host_wdata;
          A_DOUT: dout <= host_wdata;
          A_MUTE: mute <= host_wdata[1:0];
          A_DIV:  div  <= host_wdata;
          A_POL:  pol  <= host_wdata[2:0];
          default: ;
        endcase
      end
      stat <= (stat & ~clr) | {ev_done & pol[0], (ev_nack & pol[1]) | (ev_arb & pol[2])};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; cnt <= '0; step <= '0; bitn <= '0; shift <= '0;
      din <= '0; rd_op <= 1'b0; rep <= 1'b0; fail <= 1'b0; nack_s <= 1'b0;
      ev_done <= 1'b0; ev_nack <= 1'b0; ev_arb <= 1'b0;
    end else begin
      ev_done <= 1'b0; ev_nack <= 1'b0; ev_arb <= 1'b0;
      cnt <= (st == S_IDLE || tick) ? 8'd0 : cnt + 8'd1;
      if (srst) begin
        st <= S_IDLE; ph <= '0;
      end else if (op_go) begin
        st <= S_START; ph <= '0; rep <= 1'b0; step <= '0; fail <= 1'b0;
        rd_op <= host_wdata[0];
      end else if (tick) begin
        ph <= ph + 2'd1;
        case (st)
          S_START:
            if (ph == 2'd3) begin
              st <= S_TX; bitn <= '0; shift <= {dev, step == 2'd3};
            end
          S_TX: begin
            if (ph == 2'd2) begin
              if (bitn == 4'd8) nack_s <= sda_i;
              else if (shift[7] && !sda_i) begin
                st <= S_IDLE; ph <= '0; ev_arb <= 1'b1;
              end
            end
            if (ph == 2'd3) begin
              if (bitn != 4'd8) begin
                bitn <= bitn + 4'd1; shift <= {shift[6:0], 1'b0};
              end else if (nack_s) begin
                st <= S_STOP; fail <= 1'b1;
              end else if (step == 2'd2) begin
                st <= S_STOP;
              end else if (step == 2'd3) begin
                st <= S_RX; bitn <= '0;
              end else if (step == 2'd1 && rd_op) begin
                st <= S_START; rep <= 1'b1; step <= 2'd3;
              end else begin
                bitn <= '0; step <= step + 2'd1;
                shift <= (step == 2'd0) ? sub : dout;
              end
            end
          end
          S_RX: begin
            if (ph == 2'd2 && bitn != 4'd8) shift <= {shift[6:0], sda_i};
            if (ph == 2'd3) begin
              if (bitn == 4'd8) begin
                din <= shift; st <= S_STOP;
              end else bitn <= bitn + 4'd1;
            end
          end
          S_STOP:
            if (ph == 2'd3) begin
              st <= S_IDLE;
              if (fail) ev_nack <= 1'b1;
              else ev_done <= 1'b1;
            end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: begin
        scl_oe = (ph == 2'd0 && rep) || ph == 2'd3;
        sda_oe = ph[1];
      end
      S_TX: begin
        scl_oe = ph == 2'd0 || ph == 2'd3;
        sda_oe = bitn != 4'd8 && !shift[7];
      end
      S_RX:   scl_oe = ph == 2'd0 || ph == 2'd3;
      S_STOP: begin
        scl_oe = ph == 2'd0;
        sda_oe = !ph[1];
      end
      default: ;
    endcase
  end

  always_comb begin
    case (host_addr)
      A_DEV:  host_rdata = {1'b0, dev};
      A_SUB:  host_rdata = sub;
      A_DOUT: host_rdata = dout;
      A_DIN:  host_rdata = din;
      A_STAT: host_rdata = {6'd0, stat};
      A_MUTE: host_rdata = {6'd0, mute};
      A_DIV:  host_rdata = div;
      A_SRST: host_rdata = 8'h01;
      A_POL:  host_rdata = {5'd0, pol};
      default: host_rdata = 8'h00;
    endcase
  end

  // R2
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_done, ev_nack, ev_arb}));

  // R6
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == A_STAT && host_wdata[1] && !ev_done) |=> !stat[1]);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ev_done || ev_nack || ev_arb) || $past(host_we && host_addr == A_MUTE)));

  // R9
  srst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!scl_oe && !sda_oe));

  // R5
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb |-> (!scl_oe && !sda_oe));

  // R10
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && $past(st) == S_TX && sda_oe != $past(sda_oe)) |-> scl_oe);
endmodule

// File: tb/sim_ddc_i2c_master.sv
module sim_ddc_i2c_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [3:0] host_addr = 4'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic irq, scl_oe, sda_oe;
  logic slv_sda_low = 1'b0, rogue = 1'b0;
  wire scl_bus = !scl_oe;
  wire sda_bus = !(sda_oe || slv_sda_low || rogue);

  always #5 clk = ~clk;

  ddc_i2c_master u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .scl_i(scl_bus), .scl_oe(scl_oe), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  localparam logic [6:0] SLV = 7'h50;
  logic [7:0] mem [256];
  integer s_mode = 0, s_bit = 0, s_nbytes = 0, s_starts = 0, s_stops = 0;
  logic [7:0] s_sh = 8'd0, s_ptr = 8'd0;
  logic s_rd = 1'b0, s_ack = 1'b0;

  always @(negedge sda_bus) if (scl_bus) begin
    s_mode = 1; s_bit = 0; s_nbytes = 0; s_starts = s_starts + 1;
  end
  always @(posedge sda_bus) if (scl_bus) begin
    s_mode = 0; s_stops = s_stops + 1; slv_sda_low = 1'b0;
  end
  always @(posedge scl_bus) if (s_mode != 0) begin
    if (s_mode != 3 && s_bit < 8) s_sh = {s_sh[6:0], sda_bus};
    s_bit = s_bit + 1;
  end
  always @(negedge scl_bus) if (s_mode != 0) begin
    if (s_bit == 8) begin
      if (s_mode == 3) slv_sda_low = 1'b0;
      else begin
        if (s_mode == 1) begin
          s_ack = (s_sh[7:1] == SLV); s_rd = s_sh[0];
        end else begin
          s_ack = 1'b1;
          if (s_nbytes == 0) s_ptr = s_sh;
          else begin mem[s_ptr] = s_sh; s_ptr = s_ptr + 8'd1; end
          s_nbytes = s_nbytes + 1;
        end
        slv_sda_low = s_ack;
      end
    end else if (s_bit == 9) begin
      slv_sda_low = 1'b0; s_bit = 0;
      if (s_mode == 1) begin
        if (!s_ack) s_mode = 0;
        else if (s_rd) begin s_mode = 3; s_sh = mem[s_ptr]; slv_sda_low = !s_sh[7]; end
        else s_mode = 2;
      end else if (s_mode == 3) s_mode = 0;
    end else if (s_mode == 3 && s_bit >= 1 && s_bit <= 7) begin
      slv_sda_low = !s_sh[7 - s_bit];
    end
  end

  integer compared = 0, mismatched = 0;
  logic [7:0] rv;

  task automatic check(input string req, input int act, input int exp);
    compared = compared + 1;
    if (act !== exp) begin
      mismatched = mismatched + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; #1 d = host_rdata;
  endtask

  task automatic wait_stat(output logic [7:0] d);
    d = 8'd0;
    for (int i = 0; i < 6000 && d == 8'd0; i++) rreg(4'd5, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2000000;
    mismatched = mismatched + 1;
    compared = compared + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    integer st0, sp0;
    realtime t0, t1, t2;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    idle(3); rst_n = 1'b1; idle(2);

    // R1 reset state
    rreg(4'd5, rv); check("R1 status", rv, 8'h00);
    rreg(4'd6, rv); check("R1 mute", rv, 8'h03);
    rreg(4'd7, rv); check("R1 divider", rv, 8'h0B);
    rreg(4'd9, rv); check("R1 report select", rv, 8'h07);
    rreg(4'd0, rv); check("R1 target", rv, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 lines", {scl_oe, sda_oe}, 0);

    wreg(4'd7, 8'd1); wreg(4'd6, 8'd0); wreg(4'd0, SLV);

    // R2 write
    st0 = s_starts; sp0 = s_stops;
    wreg(4'd1, 8'h20); wreg(4'd2, 8'hA5); wreg(4'd4, 8'h10);
    wait_stat(rv); idle(4);
    check("R2 done status", rv, 8'h02);
    check("R2 target byte", mem[8'h20], 8'hA5);
    check("R2 one START", s_starts - st0, 1);
    check("R2 one STOP", s_stops - sp0, 1);
    check("R7 irq on done", irq, 1);
    wreg(4'd5, 8'h02); rreg(4'd5, rv);
    check("R6 clear", rv, 8'h00);
    check("R7 irq after clear", irq, 0);

    // R3 and R12 read, target address not rewritten
    mem[8'h33] = 8'h5C; mem[8'h34] = 8'h81;
    st0 = s_starts;
    wreg(4'd1, 8'h33); wreg(4'd4, 8'h01);
    wait_stat(rv); idle(4);
    check("R3 done status", rv, 8'h02);
    rreg(4'd3, rv); check("R3 data in", rv, 8'h5C);
    check("R3 repeated START", s_starts - st0, 2);
    wreg(4'd5, 8'h02);
    wreg(4'd1, 8'h34); wreg(4'd4, 8'h01);
    wait_stat(rv); idle(4);
    rreg(4'd3, rv); check("R12 second read same target", rv, 8'h81);
    wreg(4'd5, 8'h02);

    // R4 NACK on address
    wreg(4'd0, 8'h51); sp0 = s_stops;
    wreg(4'd1, 8'h60); wreg(4'd2, 8'h3C); wreg(4'd4, 8'h10);
    wait_stat(rv); idle(4);
    check("R4 error only", rv, 8'h01);
    check("R4 STOP issued", s_stops - sp0, 1);
    check("R4 no store", mem[8'h60], 8'h00);
    wreg(4'd5, 8'h01);

    // R7 mute
    wreg(4'd6, 8'h01); wreg(4'd4, 8'h10);
    wait_stat(rv); idle(4);
    check("R7 muted bit latches", rv, 8'h01);
    check("R7 muted irq low", irq, 0);
    wreg(4'd6, 8'h00); idle(1);
    check("R7 unmuted irq high", irq, 1);
    wreg(4'd5, 8'h01);

    // R8 operation during busy ignored
    wreg(4'd0, SLV); st0 = s_starts;
    wreg(4'd1, 8'h40); wreg(4'd2, 8'h11); wreg(4'd4, 8'h10);
    idle(20); wreg(4'd4, 8'h01);
    wait_stat(rv); idle(600);
    rreg(4'd5, rv);
    check("R8 busy op status", rv, 8'h02);
    check("R8 busy op no extra START", s_starts - st0, 1);
    check("R8 busy op stored", mem[8'h40], 8'h11);
    wreg(4'd5, 8'h02);

    // R8 reserved code
    st0 = s_starts;
    wreg(4'd4, 8'h02); idle(600);
    rreg(4'd5, rv);
    check("R8 reserved no status", rv, 8'h00);
    check("R8 reserved no START", s_starts - st0, 0);

    // R9 soft reset mid transaction
    wreg(4'd1, 8'h50); wreg(4'd2, 8'h77); wreg(4'd4, 8'h10);
    idle(40); wreg(4'd8, 8'h00);
    check("R9 lines released", {scl_oe, sda_oe}, 0);
    slv_sda_low = 1'b0; s_mode = 0;
    idle(600); rreg(4'd5, rv);
    check("R9 no status", rv, 8'h00);
    check("R9 no store", mem[8'h50], 8'h00);

    // R10 SCL timing with divider 3
    wreg(4'd7, 8'd3);
    wreg(4'd1, 8'h70); wreg(4'd2, 8'h0F); wreg(4'd4, 8'h10);
    @(posedge scl_bus); t0 = $realtime;
    @(negedge scl_bus); t1 = $realtime;
    @(posedge scl_bus); t2 = $realtime;
    check("R10 high time", int'((t1 - t0) / 10.0), 8);
    check("R10 period", int'((t2 - t0) / 10.0), 16);
    wait_stat(rv); idle(4);
    check("R10 done", rv, 8'h02);
    check("R10 stored", mem[8'h70], 8'h0F);
    wreg(4'd5, 8'h02); wreg(4'd7, 8'd1);

    // R11 report select
    wreg(4'd9, 8'h05); wreg(4'd0, 8'h51); sp0 = s_stops;
    wreg(4'd4, 8'h10); idle(800);
    rreg(4'd5, rv);
    check("R11 nack unreported", rv, 8'h00);
    check("R11 nack still stops", s_stops - sp0, 1);
    wreg(4'd9, 8'h06); wreg(4'd0, SLV);
    wreg(4'd1, 8'h71); wreg(4'd2, 8'h99); wreg(4'd4, 8'h10); idle(800);
    rreg(4'd5, rv);
    check("R11 done unreported", rv, 8'h00);
    check("R11 write ran", mem[8'h71], 8'h99);
    wreg(4'd9, 8'h07);

    // R5 arbitration loss
    wreg(4'd1, 8'h72); wreg(4'd2, 8'h44); wreg(4'd4, 8'h10);
    @(negedge scl_bus); rogue = 1'b1;
    wait_stat(rv);
    check("R5 error", rv, 8'h01);
    check("R5 lines released", {scl_oe, sda_oe}, 0);
    rogue = 1'b0; idle(10);
    check("R5 no store", mem[8'h72], 8'h00);

    // R6 partial clear with both bits set
    wreg(4'd1, 8'h73); wreg(4'd2, 8'h12); wreg(4'd4, 8'h10);
    idle(800); rreg(4'd5, rv);
    check("R6 both set", rv, 8'h03);
    wreg(4'd5, 8'h01); rreg(4'd5, rv);
    check("R6 clear error only", rv, 8'h02);
    wreg(4'd5, 8'h02); rreg(4'd5, rv);
    check("R6 clear done", rv, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule